// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

The arbiter keeps a record of pending interrupt sources. Sources are grouped into 32 priority levels, and each level holds 8 sources. Every level has a word of per-source pending bits. A second register, the level-status vector, holds one bit per level. A command port posts or clears a single source named by a (level, index) pair. The same port can also wipe all pending state in one cycle.

Each cycle, the block merges the level-status vector with a software request vector. Software bits cover levels 1 to 15. External levels cover levels 16 to 31. From these the block forms a winning priority and a summary mask. It then raises `take_int` when the winner is above the current priority level and the program counter is word aligned. `take_int` is combinational from registered state and the current inputs.

The hand-off to the core takes two strobes. An accept strobe captures the winner and the mask and sets a valid flag. A later update strobe copies the captured values into the summary and ID output registers and clears the flag.

Top module: `irq_level_arbiter`

## Requirements
- R1: Posting (level L, index I) sets pending bit I of level L and sets bit L of the level-status vector on the next clock edge.
- R2: Clearing (L, I) clears only that pending bit. Status bit L falls only when all 8 pending bits of level L are zero after the clear.
- R3: `clr_all` zeroes every pending word and the level-status vector at the next edge.
- R4: `take_int` is 0 whenever the level-status vector is all zero, whatever `sw_req` holds.
- R5: `take_int` is 0 whenever `pc[1:0]` is not 2'b00.
- R6: The winner is found by scanning software bits 1..15 of `sw_req` in ascending order, then status bits 16..31 in ascending order. The last set bit wins. A software bit i gives priority (i-1)+1 and an external bit i gives priority i. Every bit scanned that is set is placed at its own position in the 32-bit summary mask. Status bits 0..15 and `sw_req` bits 0 and 16..31 never enter the winner or the mask.
- R7: `take_int` is 1 only if the winner is nonzero and strictly greater than `cur_ipl`.
- R8: `accept` while `take_int` is 1 captures the winner and the mask and sets `info_valid` at the next edge. `accept` while `take_int` is 0 has no effect.
- R9: `update` while `info_valid` is 1 writes the captured mask to `isr_out` and the captured winner to `intid_out`, and clears `info_valid`. `update` while `info_valid` is 0 has no effect. If `accept` is effective in the same cycle, the previous capture is committed, the new one is latched, and `info_valid` stays 1.
- R10: A post or clear with level >= 32 or index >= 8 changes no pending state. It raises `cmd_err` for exactly the following cycle.
- R11: After reset, all pending state, `info_valid`, `isr_out`, `intid_out` and `cmd_err` are zero. Reset is asserted asynchronously and released through a two-flop synchronizer.
- R12: In one cycle, `clr_all` takes precedence over post and clear, and post takes precedence over clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_post | input | 1 | Post the addressed source |
| src_clr | input | 1 | Clear the addressed source |
| clr_all | input | 1 | Wipe all pending state |
| src_lvl | input | 6 | Source level (32..63 are out of range) |
| src_idx | input | 4 | Source index (8..15 are out of range) |
| cmd_err | output | 1 | One-cycle pulse after an out-of-range command |
| sw_req | input | 32 | Software request vector |
| cur_ipl | input | 5 | Current priority level |
| pc | input | 32 | Current program counter |
| take_int | output | 1 | Interrupt should be taken |
| accept | input | 1 | Capture winner and summary |
| update | input | 1 | Commit captured values to outputs |
| info_valid | output | 1 | A capture awaits commit |
| isr_out | output | 32 | Committed summary mask |
| intid_out | output | 5 | Committed winning priority |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is commit and capture: an `update` that retires the old capture meets an `accept` that latches a new one. The second pair is a command edit and an `accept` that reads the state that edit is about to change. The bench forces both pairs in directed steps. Random traffic then raises `accept` and `update` with high probability alongside posts and clears. A reference model applies the capture against pre-edge state and the commit against the previous capture, and the outputs are judged against that model one cycle later.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_SET   = 2'd1,
    CMD_UNSET = 2'd2,
    CMD_WIPE  = 2'd3
  } src_cmd_e;

  function automatic src_cmd_e decode_cmd(input logic post, input logic clr,
                                          input logic wipe);
    if (wipe)      return CMD_WIPE;
    else if (post) return CMD_SET;
    else if (clr)  return CMD_UNSET;
    else           return CMD_NONE;
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int SRC_N = 8,
  localparam int NUM_LVL = 1 << LVL_W,
  localparam int IDX_W = $clog2(SRC_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               post,
  input  logic               clr,
  input  logic               wipe,
  input  logic [LVL_W:0]     lvl,
  input  logic [IDX_W:0]     idx,
  output logic [NUM_LVL-1:0] status,
  output logic               err
);
  logic [NUM_LVL-1:0][SRC_N-1:0] pend_q, pend_d;
  logic [NUM_LVL-1:0]            stat_q, stat_d;
  logic                          err_q, err_d;
  logic                          addr_ok;
  logic                          bank_en;
  src_cmd_e                      cmd;
  logic [LVL_W-1:0]              l_sel;
  logic [IDX_W-1:0]              i_sel;

  assign addr_ok = (lvl < (LVL_W+1)'(NUM_LVL)) && (idx < (IDX_W+1)'(SRC_N));
  assign cmd     = decode_cmd(post, clr, wipe);
  assign l_sel   = lvl[LVL_W-1:0];
  assign i_sel   = idx[IDX_W-1:0];
  assign err_d   = (post || clr) && !addr_ok;
  assign bank_en = (cmd == CMD_WIPE) || ((cmd != CMD_NONE) && addr_ok);

  always_comb begin
    pend_d = pend_q;
    stat_d = stat_q;
    case (cmd)
      CMD_WIPE: begin
        pend_d = '0;
        stat_d = '0;
      end
      CMD_SET: begin
        pend_d[l_sel][i_sel] = 1'b1;
        stat_d[l_sel]        = 1'b1;
      end
      CMD_UNSET: begin
        pend_d[l_sel][i_sel] = 1'b0;
        stat_d[l_sel]        = |pend_d[l_sel];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      stat_q <= '0;
    end else if (bank_en) begin
      pend_q <= pend_d;
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign status = stat_q;
  assign err    = err_q;
endmodule

// File: rtl/irq_prio_merge.sv
module irq_prio_merge #(
  parameter int LVL_W   = 5,
  parameter int SW_MIN  = 1,
  parameter int SW_MAX  = 16,
  parameter int EXT_MIN = 16,
  parameter int EXT_MAX = 32,
  localparam int NUM_LVL = 1 << LVL_W
) (
  input  logic [NUM_LVL-1:0] sw_req,
  input  logic [NUM_LVL-1:0] status,
  output logic [LVL_W-1:0]   win,
  output logic [NUM_LVL-1:0] summary
);
  // Ascending scans, software first; a later hit overwrites an earlier one.
  always_comb begin
    win     = '0;
    summary = '0;
    for (int i = SW_MIN; i < SW_MAX; i++) begin
      if (sw_req[i]) begin
        win        = LVL_W'(i - SW_MIN + 1);
        summary[i] = 1'b1;
      end
    end
    for (int i = EXT_MIN; i < EXT_MAX; i++) begin
      if (status[i]) begin
        win        = LVL_W'(i);
        summary[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_commit.sv
module irq_commit #(
  parameter int LVL_W = 5,
  localparam int NUM_LVL = 1 << LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic               update,
  input  logic [LVL_W-1:0]   win,
  input  logic [NUM_LVL-1:0] summary,
  output logic               valid,
  output logic [LVL_W-1:0]   lat_win,
  output logic [NUM_LVL-1:0] lat_sum,
  output logic [NUM_LVL-1:0] isr,
  output logic [LVL_W-1:0]   intid
);
  logic               valid_q, valid_d;
  logic [LVL_W-1:0]   lwin_q, id_q;
  logic [NUM_LVL-1:0] lsum_q, isr_q;
  logic               commit_en;

  assign commit_en = update && valid_q;

  always_comb begin
    valid_d = valid_q;
    if (cap_en)         valid_d = 1'b1;
    else if (commit_en) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lwin_q <= '0;
      lsum_q <= '0;
    end else if (cap_en) begin
      lwin_q <= win;
      lsum_q <= summary;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      id_q  <= '0;
    end else if (commit_en) begin
      isr_q <= lsum_q;
      id_q  <= lwin_q;
    end
  end

  assign valid   = valid_q;
  assign lat_win = lwin_q;
  assign lat_sum = lsum_q;
  assign isr     = isr_q;
  assign intid   = id_q;
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int LVL_W   = 5,
  parameter int SRC_N   = 8,
  parameter int SW_MIN  = 1,
  parameter int SW_MAX  = 16,
  parameter int EXT_MIN = 16,
  parameter int EXT_MAX = 32,
  parameter int PC_W    = 32,
  localparam int NUM_LVL = 1 << LVL_W,
  localparam int IDX_W   = $clog2(SRC_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src_post,
  input  logic               src_clr,
  input  logic               clr_all,
  input  logic [LVL_W:0]     src_lvl,
  input  logic [IDX_W:0]     src_idx,
  output logic               cmd_err,
  input  logic [NUM_LVL-1:0] sw_req,
  input  logic [LVL_W-1:0]   cur_ipl,
  input  logic [PC_W-1:0]    pc,
  output logic               take_int,
  input  logic               accept,
  input  logic               update,
  output logic               info_valid,
  output logic [NUM_LVL-1:0] isr_out,
  output logic [LVL_W-1:0]   intid_out
);
  logic [1:0]         rst_sync_q;
  logic               rst_sync_n;
  logic [NUM_LVL-1:0] status;
  logic [LVL_W-1:0]   win;
  logic [NUM_LVL-1:0] summary;
  logic [LVL_W-1:0]   lat_win;
  logic [NUM_LVL-1:0] lat_sum;
  logic               pc_aligned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  irq_src_bank #(.LVL_W(LVL_W), .SRC_N(SRC_N)) bank_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .post   (src_post),
    .clr    (src_clr),
    .wipe   (clr_all),
    .lvl    (src_lvl),
    .idx    (src_idx),
    .status (status),
    .err    (cmd_err)
  );

  irq_prio_merge #(
    .LVL_W(LVL_W), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
    .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX)
  ) merge_i (
    .sw_req  (sw_req),
    .status  (status),
    .win     (win),
    .summary (summary)
  );

  assign pc_aligned = (pc[1:0] == 2'b00);
  assign take_int   = (|status) && pc_aligned && (win != '0) && (win > cur_ipl);

  irq_commit #(.LVL_W(LVL_W)) commit_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cap_en  (accept && take_int),
    .update  (update),
    .win     (win),
    .summary (summary),
    .valid   (info_valid),
    .lat_win (lat_win),
    .lat_sum (lat_sum),
    .isr     (isr_out),
    .intid   (intid_out)
  );
endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
  parameter int LVL_W = 5,
  parameter int SRC_N = 8,
  parameter int PC_W  = 32,
  localparam int NUM_LVL = 1 << LVL_W,
  localparam int IDX_W   = $clog2(SRC_N)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               src_post,
  input logic               src_clr,
  input logic               clr_all,
  input logic [LVL_W:0]     src_lvl,
  input logic [IDX_W:0]     src_idx,
  input logic               cmd_err,
  input logic [LVL_W-1:0]   cur_ipl,
  input logic [PC_W-1:0]    pc,
  input logic               take_int,
  input logic               accept,
  input logic               update,
  input logic               info_valid,
  input logic [NUM_LVL-1:0] isr_out,
  input logic [LVL_W-1:0]   intid_out,
  input logic [NUM_LVL-1:0] status,
  input logic [LVL_W-1:0]   win,
  input logic [LVL_W-1:0]   lat_win,
  input logic [NUM_LVL-1:0] lat_sum
);
  p_empty_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !take_int);

  p_pc_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc[1:0] != 2'b00) |-> !take_int);

  p_strict_ipl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_int |-> (win > cur_ipl));

  p_wipe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (status == '0));

  p_bad_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_post || src_clr) &&
     ((src_lvl >= (LVL_W+1)'(NUM_LVL)) || (src_idx >= (IDX_W+1)'(SRC_N))))
    |=> cmd_err);

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && take_int) |=> (info_valid && (lat_win == $past(win))));

  p_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (update && info_valid) |=>
      ((isr_out == $past(lat_sum)) && (intid_out == $past(lat_win))));

  p_idle_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (update && !info_valid) |=> ($stable(isr_out) && $stable(intid_out)));
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
  .LVL_W(LVL_W), .SRC_N(SRC_N), .PC_W(PC_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .src_post   (src_post),
  .src_clr    (src_clr),
  .clr_all    (clr_all),
  .src_lvl    (src_lvl),
  .src_idx    (src_idx),
  .cmd_err    (cmd_err),
  .cur_ipl    (cur_ipl),
  .pc         (pc),
  .take_int   (take_int),
  .accept     (accept),
  .update     (update),
  .info_valid (info_valid),
  .isr_out    (isr_out),
  .intid_out  (intid_out),
  .status     (status),
  .win        (win),
  .lat_win    (lat_win),
  .lat_sum    (lat_sum)
);

// File: tb/irq_level_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_level_arbiter_tb_top;
  localparam int NL = 32;
  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_post = 0, src_clr = 0, clr_all = 0;
  logic [5:0]  src_lvl = '0;
  logic [3:0]  src_idx = '0;
  logic        cmd_err;
  logic [31:0] sw_req = '0;
  logic [4:0]  cur_ipl = '0;
  logic [31:0] pc = '0;
  logic        take_int;
  logic        accept = 0, update = 0;
  logic        info_valid;
  logic [31:0] isr_out;
  logic [4:0]  intid_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  m_pend [NL];
  logic [31:0] m_stat;
  logic        m_valid, m_err;
  logic [4:0]  m_lwin, m_id;
  logic [31:0] m_lsum, m_isr;

  always #2 clk = ~clk;

  irq_level_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .src_post(src_post), .src_clr(src_clr),
    .clr_all(clr_all), .src_lvl(src_lvl), .src_idx(src_idx), .cmd_err(cmd_err),
    .sw_req(sw_req), .cur_ipl(cur_ipl), .pc(pc), .take_int(take_int),
    .accept(accept), .update(update), .info_valid(info_valid),
    .isr_out(isr_out), .intid_out(intid_out)
  );

  function automatic logic [4:0] f_win(logic [31:0] sw, logic [31:0] st);
    logic [4:0] w = '0;
    for (int i = 1; i < 16; i++) if (sw[i]) w = 5'(i - 1 + 1);
    for (int i = 16; i < 32; i++) if (st[i]) w = 5'(i);
    return w;
  endfunction

  function automatic logic [31:0] f_sum(logic [31:0] sw, logic [31:0] st);
    logic [31:0] s = '0;
    for (int i = 1; i < 16; i++) if (sw[i]) s[i] = 1'b1;
    for (int i = 16; i < 32; i++) if (st[i]) s[i] = 1'b1;
    return s;
  endfunction

  function automatic logic f_take(logic [31:0] sw, logic [31:0] st,
                                  logic [4:0] ipl, logic [31:0] p);
    logic [4:0] w = f_win(sw, st);
    return (st != 0) && (p[1:0] == 2'b00) && (w != 0) && (w > ipl);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int l = 0; l < NL; l++) m_pend[l] = '0;
    m_stat = '0; m_valid = 0; m_err = 0;
    m_lwin = '0; m_id = '0; m_lsum = '0; m_isr = '0;
  endtask

  // One cycle: check registered outputs, drive, check take_int, update model.
  task automatic cyc(bit p, bit c, bit a, int lvl, int idx, logic [31:0] sw,
                     logic [4:0] ipl, logic [31:0] pcv, bit acc, bit upd,
                     string req);
    bit ok_addr, acc_eff, tk;
    logic [4:0] w;
    logic [31:0] s;
    @(negedge clk);
    chk(cmd_err == m_err, "R10 err", 64'(cmd_err), 64'(m_err));
    chk(info_valid == m_valid, "R8 valid", 64'(info_valid), 64'(m_valid));
    chk(isr_out == m_isr, "R9 isr", 64'(isr_out), 64'(m_isr));
    chk(intid_out == m_id, "R9 intid", 64'(intid_out), 64'(m_id));
    src_post = p; src_clr = c; clr_all = a;
    src_lvl = 6'(lvl); src_idx = 4'(idx);
    sw_req = sw; cur_ipl = ipl; pc = pcv; accept = acc; update = upd;
    #1;
    tk = f_take(sw, m_stat, ipl, pcv);
    chk(take_int == tk, req, 64'(take_int), 64'(tk));
    w = f_win(sw, m_stat);
    s = f_sum(sw, m_stat);
    acc_eff = acc && tk;
    ok_addr = (lvl < NL) && (idx < NS);
    m_err = (p || c) && !ok_addr;
    if (a) begin
      for (int l = 0; l < NL; l++) m_pend[l] = '0;
      m_stat = '0;
    end else if (p && ok_addr) begin
      m_pend[lvl][idx] = 1'b1;
      m_stat[lvl] = 1'b1;
    end else if (c && ok_addr) begin
      m_pend[lvl][idx] = 1'b0;
      m_stat[lvl] = (m_pend[lvl] != 0);
    end
    if (upd && m_valid) begin
      m_isr = m_lsum;
      m_id  = m_lwin;
    end
    if (acc_eff) begin
      m_lwin = w; m_lsum = s; m_valid = 1'b1;
    end else if (upd && m_valid) begin
      m_valid = 1'b0;
    end
  endtask

  task automatic idle(logic [31:0] sw, logic [4:0] ipl, logic [31:0] pcv, string req);
    cyc(0, 0, 0, 0, 0, sw, ipl, pcv, 0, 0, req);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(take_int == 0, "R11 take", 64'(take_int), 0);
    chk(info_valid == 0, "R11 valid", 64'(info_valid), 0);
    chk(isr_out == 0, "R11 isr", 64'(isr_out), 0);
    chk(intid_out == 0, "R11 intid", 64'(intid_out), 0);
    chk(cmd_err == 0, "R11 err", 64'(cmd_err), 0);

    idle(32'h0000_0020, 0, 0, "R4 sw only, no status");
    cyc(1, 0, 0, 20, 0, 32'h20, 0, 0, 0, 0, "R4 before post");
    idle(32'h20, 0, 0, "R1 posted level 20 takes");
    idle(32'h20, 0, 32'h1001, "R5 misaligned pc");
    idle(32'h20, 0, 32'h1002, "R5 misaligned pc");
    idle(32'h20, 20, 0, "R7 equal ipl blocks");
    idle(32'h20, 19, 0, "R7 lower ipl passes");
    cyc(0, 0, 0, 0, 0, 32'h20, 0, 0, 1, 0, "R8 accept level 20");
    cyc(0, 0, 0, 0, 0, 32'h20, 0, 0, 0, 1, "R9 commit");
    idle(32'h20, 0, 0, "R6 external overrides software");
    cyc(1, 0, 0, 20, 3, 0, 0, 0, 0, 0, "R2 post second source");
    cyc(0, 1, 0, 20, 0, 0, 0, 0, 0, 0, "R2 clear first source");
    idle(0, 0, 0, "R2 level still pending");
    cyc(0, 1, 0, 20, 3, 0, 0, 0, 0, 0, "R2 clear last source");
    idle(0, 0, 0, "R2 level dropped");
    cyc(1, 0, 0, 3, 5, 32'h80, 0, 0, 0, 0, "R4 low level post");
    idle(32'h80, 6, 0, "R6 software bit 7 gives 7");
    cyc(0, 0, 0, 0, 0, 32'h80, 0, 0, 1, 0, "R8 accept software");
    cyc(0, 0, 0, 0, 0, 32'h8001_0081, 0, 0, 0, 1, "R6 masked sw bits");
    idle(32'h0, 0, 0, "R6 low status level only");
    cyc(1, 0, 0, 40, 2, 32'h80, 0, 0, 0, 0, "R10 bad level");
    cyc(1, 0, 0, 25, 9, 32'h80, 0, 0, 0, 0, "R10 bad index");
    cyc(0, 1, 0, 3, 12, 32'h80, 0, 0, 0, 0, "R10 bad clear index");
    idle(32'h80, 0, 0, "R10 state untouched");
    cyc(1, 1, 0, 30, 1, 0, 0, 0, 0, 0, "R12 post beats clear");
    idle(0, 0, 0, "R12 level 30 pending");
    cyc(1, 0, 1, 31, 1, 0, 0, 0, 0, 0, "R12 wipe beats post");
    idle(32'hFFFF, 0, 0, "R3 all wiped");
    cyc(0, 0, 0, 0, 0, 32'hFFFF, 0, 0, 1, 0, "R8 ignored accept");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 ignored update");
    cyc(1, 0, 0, 17, 0, 0, 0, 0, 0, 0, "R1 post 17");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R8 accept 17");
    cyc(1, 0, 0, 28, 4, 0, 0, 0, 1, 1, "R9 accept with commit");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R9 accept with commit");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 final commit");
    idle(0, 0, 0, "R9 settle");

    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      bit p = (r < 35);
      bit c = (r >= 35 && r < 65);
      bit a = (r == 99);
      logic [31:0] pcv = {$urandom, 2'b00};
      if ($urandom % 4 == 0) pcv[1:0] = 2'($urandom % 3 + 1);
      cyc(p, c, a, int'($urandom % 48), int'($urandom % 10),
          $urandom & 32'h0000_FFFF & ($urandom | $urandom),
          5'($urandom), pcv, ($urandom % 3) != 0, ($urandom % 2) == 0,
          "R6 R7 random take");
    end
    idle(0, 0, 0, "R9 drain");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule